// File: doc/BRIEF.md
# Mailbox Lock and Command Controller

This block arbitrates a shared message buffer between several external requesters and an internal microcontroller. A requester claims the buffer by reading a lock register. If the buffer is free, the read returns 0 and the block records that requester's bus user ID as the owner. From then on, only accesses that carry that ID may change the command word, the data length, the buffer contents or the execute bit. Guarded writes from any other ID are discarded and raise a one-cycle access-error pulse.

When the owner sets the execute bit, a one-cycle interrupt tells the microcontroller that a command is waiting. The microcontroller reports progress through a two-bit status field. It can also force-release the lock at any time, which lets it recover when an owner stalls or the buffer is deadlocked.

The buffer SRAM lies outside the block. It appears only as a write enable, a word address and write data. The buffer size is a parameter, with a 16 KiB default.

Top module: `mbox_lock_ctrl`

## Requirements
- R1: A read of the lock register (address 0) while the buffer is free returns 0 in bit 0. At the next clock edge the lock is held and the reading ID becomes the owner.
- R2: A lock read while the lock is held returns 1 in bit 0 and leaves the owner unchanged.
- R3: A write from a non-owner ID to command (address 2), length (3), data (4) or execute (5) is dropped. `accErr` is high for exactly the one cycle after that write.
- R4: Each owner write to the data address drives `memWe` in the same cycle. `memAddr` starts at 0 after every new grant and advances by one word per accepted write.
- R5: An owner write of 1 to bit 0 of the execute register sets the execute bit. `cmdIrq` is high for the single cycle in which the execute bit first reads as set.
- R6: A status update from the microcontroller is accepted only while the execute bit is set. At any other time it has no effect.
- R7: Status codes are 2'b00 busy/idle, 2'b01 data ready, 2'b10 complete and 2'b11 failure. A read of address 6 returns the execute bit in bit 2 and the status in bits 1:0.
- R8: An owner write of 0 to bit 0 of the execute register releases the lock, clears the execute bit and returns the status to 2'b00 at the next edge. This release takes priority over a status update in the same cycle.
- R9: `uForceRel` clears the lock, the owner, the execute bit and the status at the next edge. It overrides every request made in the same cycle, including a lock read.
- R10: After reset, the lock, the owner, the execute bit, the status, `cmdIrq`, `accErr` and `memWe` are all 0.
- R11: A read of address 1 returns the owner ID in bits USER_W-1:0 and the lock bit in bit USER_W. A read of address 3 returns the stored length. Reads of other addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| regEn | input | 1 | Register access valid this cycle |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 3 | Register select |
| regUser | input | USER_W | User ID of the requester |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data, combinational in the access cycle |
| uStatusWe | input | 1 | Microcontroller status update strobe |
| uStatusVal | input | 2 | New status code |
| uForceRel | input | 1 | Microcontroller force-release |
| cmdIrq | output | 1 | Command-waiting interrupt pulse |
| accErr | output | 1 | Rejected-write pulse |
| lockHeld | output | 1 | Lock currently held |
| execOn | output | 1 | Execute bit |
| mboxStatus | output | 2 | Status field |
| memWe | output | 1 | Buffer write enable |
| memAddr | output | ADDR_W | Buffer word address |
| memWdata | output | DATA_W | Buffer write data |

## Verification
The assertions check on every cycle that the interrupt is a single pulse tied to the rising edge of the execute bit, and that the execute bit is never set without a held lock. They also check that the status stays 2'b00 whenever the execute bit is clear, that force-release always leaves an empty mailbox, and that buffer writes and error pulses occur only when their causes are present. Only the bench scenarios can show that ownership follows the correct user ID, that rejected writes leave the stored command untouched, and that the buffer address restarts at each new grant. They also show the read formats and the priority orderings.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [2:0] {
    REG_LOCK   = 3'd0,
    REG_OWNER  = 3'd1,
    REG_CMD    = 3'd2,
    REG_DLEN   = 3'd3,
    REG_DATA   = 3'd4,
    REG_EXEC   = 3'd5,
    REG_STATUS = 3'd6
  } regSel_e;

  typedef enum logic [1:0] {
    ST_BUSY   = 2'b00,
    ST_DREADY = 2'b01,
    ST_DONE   = 2'b10,
    ST_FAIL   = 2'b11
  } mbStatus_e;

  typedef struct packed {
    logic grab;
    logic freeLock;
    logic ldCmd;
    logic ldLen;
    logic pushData;
    logic setExec;
    logic ldStatus;
    logic flagErr;
  } ctrlStrobe_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int USER_W = 8
) (
  input  logic              regEn,
  input  logic              regWrite,
  input  logic [2:0]        regAddr,
  input  logic              execBitIn,
  input  logic [USER_W-1:0] regUser,
  input  logic              uStatusWe,
  input  logic              uForceRel,
  input  logic              lockHeld,
  input  logic [USER_W-1:0] ownerId,
  input  logic              execOn,
  output ctrlStrobe_t       strobe
);
  logic isOwner;
  logic isRead;
  logic isWrite;
  logic guarded;
  regSel_e sel;

  always_comb begin
    sel     = regSel_e'(regAddr);
    isOwner = lockHeld && (regUser == ownerId);
    isRead  = regEn && !regWrite;
    isWrite = regEn && regWrite;
    guarded = isWrite && ((sel == REG_CMD) || (sel == REG_DLEN) ||
                          (sel == REG_DATA) || (sel == REG_EXEC));
    strobe  = '0;
    if (uForceRel) begin
      strobe.freeLock = 1'b1;
    end else begin
      strobe.grab     = isRead && (sel == REG_LOCK) && !lockHeld;
      strobe.flagErr  = guarded && !isOwner;
      strobe.ldStatus = uStatusWe && execOn;
      if (guarded && isOwner) begin
        case (sel)
          REG_CMD:  strobe.ldCmd    = 1'b1;
          REG_DLEN: strobe.ldLen    = 1'b1;
          REG_DATA: strobe.pushData = 1'b1;
          REG_EXEC: begin
            if (execBitIn) strobe.setExec  = 1'b1;
            else           strobe.freeLock = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mbox_dpath.sv
module mbox_dpath
  import mbox_pkg::*;
#(
  parameter int USER_W = 8,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4096,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              regEn,
  input  logic              regWrite,
  input  logic [2:0]        regAddr,
  input  logic [USER_W-1:0] regUser,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [1:0]        uStatusVal,
  output logic [DATA_W-1:0] regRdata,
  output logic              lockHeld,
  output logic [USER_W-1:0] ownerId,
  output logic              execOn,
  output logic [1:0]        mboxStatus,
  output logic              cmdIrq,
  output logic              accErr,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);
  logic [DATA_W-1:0] cmdReg;
  logic [DATA_W-1:0] lenReg;
  logic [ADDR_W-1:0] wrPtr;
  mbStatus_e         statusReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockHeld  <= 1'b0;
      ownerId   <= '0;
      execOn    <= 1'b0;
      statusReg <= ST_BUSY;
      cmdReg    <= '0;
      lenReg    <= '0;
      wrPtr     <= '0;
      cmdIrq    <= 1'b0;
      accErr    <= 1'b0;
    end else begin
      cmdIrq <= strobe.setExec && !execOn;
      accErr <= strobe.flagErr;
      if (strobe.freeLock) begin
        lockHeld  <= 1'b0;
        ownerId   <= '0;
        execOn    <= 1'b0;
        statusReg <= ST_BUSY;
      end else begin
        if (strobe.grab) begin
          lockHeld <= 1'b1;
          ownerId  <= regUser;
          wrPtr    <= '0;
        end
        if (strobe.ldCmd) cmdReg <= regWdata;
        if (strobe.ldLen) lenReg <= regWdata;
        if (strobe.pushData) begin
          if (wrPtr == ADDR_W'(DEPTH - 1)) wrPtr <= '0;
          else                             wrPtr <= wrPtr + 1'b1;
        end
        if (strobe.setExec)  execOn    <= 1'b1;
        if (strobe.ldStatus) statusReg <= mbStatus_e'(uStatusVal);
      end
    end
  end

  always_comb begin
    regRdata = '0;
    if (regEn && !regWrite) begin
      case (regSel_e'(regAddr))
        REG_LOCK:   regRdata[0] = lockHeld;
        REG_OWNER: begin
          regRdata[USER_W-1:0] = ownerId;
          regRdata[USER_W]     = lockHeld;
        end
        REG_CMD:    regRdata = cmdReg;
        REG_DLEN:   regRdata = lenReg;
        REG_STATUS: begin
          regRdata[1:0] = statusReg;
          regRdata[2]   = execOn;
        end
        default: regRdata = '0;
      endcase
    end
  end

  assign mboxStatus = statusReg;
  assign memWe      = strobe.pushData;
  assign memAddr    = wrPtr;
  assign memWdata   = regWdata;
endmodule

// File: rtl/mbox_lock_ctrl.sv
module mbox_lock_ctrl
  import mbox_pkg::*;
#(
  parameter int USER_W    = 8,
  parameter int DATA_W    = 32,
  parameter int BUF_BYTES = 16384,
  localparam int DEPTH    = BUF_BYTES / (DATA_W / 8),
  localparam int ADDR_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regEn,
  input  logic              regWrite,
  input  logic [2:0]        regAddr,
  input  logic [USER_W-1:0] regUser,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              uStatusWe,
  input  logic [1:0]        uStatusVal,
  input  logic              uForceRel,
  output logic              cmdIrq,
  output logic              accErr,
  output logic              lockHeld,
  output logic              execOn,
  output logic [1:0]        mboxStatus,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);
  ctrlStrobe_t       strobe;
  logic [USER_W-1:0] ownerId;

  mbox_ctrl #(.USER_W(USER_W)) ctrl_i (
    .regEn(regEn), .regWrite(regWrite), .regAddr(regAddr),
    .execBitIn(regWdata[0]), .regUser(regUser),
    .uStatusWe(uStatusWe), .uForceRel(uForceRel),
    .lockHeld(lockHeld), .ownerId(ownerId), .execOn(execOn),
    .strobe(strobe)
  );

  mbox_dpath #(.USER_W(USER_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .regEn(regEn), .regWrite(regWrite), .regAddr(regAddr),
    .regUser(regUser), .regWdata(regWdata), .uStatusVal(uStatusVal),
    .regRdata(regRdata), .lockHeld(lockHeld), .ownerId(ownerId),
    .execOn(execOn), .mboxStatus(mboxStatus), .cmdIrq(cmdIrq),
    .accErr(accErr), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata)
  );
endmodule

// File: rtl/mbox_lock_ctrl_chk.sv
module mbox_lock_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       regEn,
  input logic       regWrite,
  input logic       uForceRel,
  input logic       cmdIrq,
  input logic       accErr,
  input logic       lockHeld,
  input logic       execOn,
  input logic [1:0] mboxStatus,
  input logic       memWe
);
  p_irq_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmdIrq |=> !cmdIrq);
  p_irq_on_exec_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmdIrq |-> (execOn && !$past(execOn)));
  p_exec_needs_lock_r8: assert property (@(posedge clk) disable iff (!rstN)
    execOn |-> lockHeld);
  p_status_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !execOn |-> (mboxStatus == 2'b00));
  p_force_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    uForceRel |=> (!lockHeld && !execOn && mboxStatus == 2'b00));
  p_err_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    accErr |-> $past(regEn && regWrite));
  p_write_owned_r4: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> lockHeld);
endmodule

bind mbox_lock_ctrl mbox_lock_ctrl_chk chk_i (.*);

// File: tb/mbox_lock_ctrl_tb_top.sv
module mbox_lock_ctrl_tb_top;
  localparam int UW = 8;
  localparam int DW = 32;
  localparam logic [7:0] UA = 8'h11;
  localparam logic [7:0] UB = 8'h22;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regEn = 1'b0, regWrite = 1'b0, uStatusWe = 1'b0, uForceRel = 1'b0;
  logic [2:0] regAddr = '0;
  logic [UW-1:0] regUser = '0;
  logic [DW-1:0] regWdata = '0;
  logic [1:0] uStatusVal = '0;
  logic [DW-1:0] regRdata, memWdata;
  logic cmdIrq, accErr, lockHeld, execOn, memWe;
  logic [1:0] mboxStatus;
  logic [11:0] memAddr;
  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  mbox_lock_ctrl dut_i (
    .clk(clk), .rstN(rstN), .regEn(regEn), .regWrite(regWrite),
    .regAddr(regAddr), .regUser(regUser), .regWdata(regWdata),
    .regRdata(regRdata), .uStatusWe(uStatusWe), .uStatusVal(uStatusVal),
    .uForceRel(uForceRel), .cmdIrq(cmdIrq), .accErr(accErr),
    .lockHeld(lockHeld), .execOn(execOn), .mboxStatus(mboxStatus),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata)
  );

  typedef struct packed {
    logic        en;
    logic        wr;
    logic [2:0]  addr;
    logic [7:0]  user;
    logic [31:0] wdata;
    logic        stWe;
    logic [1:0]  stVal;
    logic        frc;
    logic [31:0] expRd;
    logic        expLock;
    logic        expExec;
    logic [1:0]  expSt;
    logic        expIrq;
    logic        expErr;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,3'd0,UA,32'h0,1'b0,2'd0,1'b0,32'h0,  1'b1,1'b0,2'd0,1'b0,1'b0,8'd1},  // R1 grab by A
    '{1'b1,1'b0,3'd0,UB,32'h0,1'b0,2'd0,1'b0,32'h1,  1'b1,1'b0,2'd0,1'b0,1'b0,8'd2},  // R2 held
    '{1'b1,1'b0,3'd1,UB,32'h0,1'b0,2'd0,1'b0,32'h111,1'b1,1'b0,2'd0,1'b0,1'b0,8'd11}, // R11 owner A
    '{1'b1,1'b1,3'd2,UA,32'h55,1'b0,2'd0,1'b0,32'h0, 1'b1,1'b0,2'd0,1'b0,1'b0,8'd3},  // R3 owner cmd
    '{1'b1,1'b1,3'd2,UB,32'h99,1'b0,2'd0,1'b0,32'h0, 1'b1,1'b0,2'd0,1'b0,1'b1,8'd3},  // R3 rejected
    '{1'b1,1'b0,3'd2,UB,32'h0,1'b0,2'd0,1'b0,32'h55, 1'b1,1'b0,2'd0,1'b0,1'b0,8'd3},  // R3 cmd intact
    '{1'b1,1'b1,3'd5,UB,32'h1,1'b0,2'd0,1'b0,32'h0,  1'b1,1'b0,2'd0,1'b0,1'b1,8'd3},  // R3 exec rejected
    '{1'b0,1'b0,3'd0,UA,32'h0,1'b1,2'd2,1'b0,32'h0,  1'b1,1'b0,2'd0,1'b0,1'b0,8'd6},  // R6 ignored
    '{1'b1,1'b1,3'd5,UA,32'h1,1'b0,2'd0,1'b0,32'h0,  1'b1,1'b1,2'd0,1'b1,1'b0,8'd5},  // R5 irq
    '{1'b0,1'b0,3'd0,UA,32'h0,1'b0,2'd0,1'b0,32'h0,  1'b1,1'b1,2'd0,1'b0,1'b0,8'd5},  // R5 pulse ends
    '{1'b0,1'b0,3'd0,UA,32'h0,1'b1,2'd1,1'b0,32'h0,  1'b1,1'b1,2'd1,1'b0,1'b0,8'd7},  // R7 data ready
    '{1'b1,1'b0,3'd6,UB,32'h0,1'b1,2'd2,1'b0,32'h5,  1'b1,1'b1,2'd2,1'b0,1'b0,8'd7},  // R7 read + complete
    '{1'b1,1'b0,3'd6,UA,32'h0,1'b0,2'd0,1'b0,32'h6,  1'b1,1'b1,2'd2,1'b0,1'b0,8'd7},  // R7 read
    '{1'b0,1'b0,3'd0,UA,32'h0,1'b1,2'd3,1'b0,32'h0,  1'b1,1'b1,2'd3,1'b0,1'b0,8'd7},  // R7 failure
    '{1'b1,1'b1,3'd5,UA,32'h0,1'b1,2'd1,1'b0,32'h0,  1'b0,1'b0,2'd0,1'b0,1'b0,8'd8},  // R8 release wins
    '{1'b1,1'b0,3'd0,UB,32'h0,1'b0,2'd0,1'b0,32'h0,  1'b1,1'b0,2'd0,1'b0,1'b0,8'd1},  // R1 grab by B
    '{1'b1,1'b0,3'd1,UA,32'h0,1'b0,2'd0,1'b0,32'h122,1'b1,1'b0,2'd0,1'b0,1'b0,8'd11}, // R11 owner B
    '{1'b1,1'b1,3'd5,UB,32'h1,1'b0,2'd0,1'b0,32'h0,  1'b1,1'b1,2'd0,1'b1,1'b0,8'd5},  // R5
    '{1'b0,1'b0,3'd0,UA,32'h0,1'b1,2'd2,1'b0,32'h0,  1'b1,1'b1,2'd2,1'b0,1'b0,8'd7},  // R7
    '{1'b1,1'b0,3'd0,UA,32'h0,1'b0,2'd0,1'b1,32'h1,  1'b0,1'b0,2'd0,1'b0,1'b0,8'd9},  // R9 force over grab
    '{1'b1,1'b0,3'd1,UA,32'h0,1'b0,2'd0,1'b0,32'h0,  1'b0,1'b0,2'd0,1'b0,1'b0,8'd9},  // R9 owner cleared
    '{1'b1,1'b0,3'd0,UA,32'h0,1'b0,2'd0,1'b0,32'h0,  1'b1,1'b0,2'd0,1'b0,1'b0,8'd1}   // R1 regrab by A
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic en, input logic wr, input logic [2:0] addr,
                       input logic [7:0] user, input logic [31:0] wd);
    @(negedge clk);
    regEn = en; regWrite = wr; regAddr = addr; regUser = user; regWdata = wd;
    uStatusWe = 1'b0; uForceRel = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
    regEn = 1'b0; regWrite = 1'b0; uStatusWe = 1'b0; uForceRel = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 lock", {31'b0, lockHeld}, 0);
    chk("R10 exec", {31'b0, execOn}, 0);
    chk("R10 status", {30'b0, mboxStatus}, 0);
    chk("R10 irq/err/we", {29'b0, cmdIrq, accErr, memWe}, 0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      @(negedge clk);
      regEn = VECS[i].en; regWrite = VECS[i].wr; regAddr = VECS[i].addr;
      regUser = VECS[i].user; regWdata = VECS[i].wdata;
      uStatusWe = VECS[i].stWe; uStatusVal = VECS[i].stVal; uForceRel = VECS[i].frc;
      tag = $sformatf("R%0d row%0d", VECS[i].req, i);
      #1;
      if (VECS[i].en && !VECS[i].wr) chk({tag, " rdata"}, regRdata, VECS[i].expRd);
      @(posedge clk); #1;
      chk({tag, " lock"}, {31'b0, lockHeld}, {31'b0, VECS[i].expLock});
      chk({tag, " exec"}, {31'b0, execOn}, {31'b0, VECS[i].expExec});
      chk({tag, " status"}, {30'b0, mboxStatus}, {30'b0, VECS[i].expSt});
      chk({tag, " irq"}, {31'b0, cmdIrq}, {31'b0, VECS[i].expIrq});
      chk({tag, " err"}, {31'b0, accErr}, {31'b0, VECS[i].expErr});
    end

    // R4: buffer writes by owner A (lock held by A after table)
    drive(1'b1, 1'b1, 3'd4, UA, 32'hAA); #1;
    chk("R4 we0", {31'b0, memWe}, 1);
    chk("R4 addr0", {20'b0, memAddr}, 0);
    chk("R4 wdata", memWdata, 32'hAA);
    drive(1'b1, 1'b1, 3'd4, UA, 32'hBB); #1;
    chk("R4 addr1", {20'b0, memAddr}, 1);
    drive(1'b1, 1'b1, 3'd4, UB, 32'hCC); #1;
    chk("R4 R3 non-owner no write", {31'b0, memWe}, 0);
    @(posedge clk); #1;
    chk("R3 data err", {31'b0, accErr}, 1);
    drive(1'b1, 1'b1, 3'd3, UA, 32'h40);
    drive(1'b1, 1'b0, 3'd3, UB, 32'h0); #1;
    chk("R11 length read", regRdata, 32'h40);
    drive(1'b1, 1'b0, 3'd4, UB, 32'h0); #1;
    chk("R11 data read zero", regRdata, 32'h0);
    drive(1'b1, 1'b1, 3'd5, UA, 32'h0);
    drive(1'b1, 1'b0, 3'd0, UA, 32'h0);
    drive(1'b1, 1'b1, 3'd4, UA, 32'hDD); #1;
    chk("R4 addr restarts", {20'b0, memAddr}, 0);
    chk("R4 we regrab", {31'b0, memWe}, 1);

    // R10: reset while locked and executing
    drive(1'b1, 1'b1, 3'd5, UA, 32'h1);
    idle();
    chk("R10 pre exec", {31'b0, execOn}, 1);
    rstN = 1'b0; #1;
    chk("R10 lock after reset", {31'b0, lockHeld}, 0);
    chk("R10 exec after reset", {31'b0, execOn}, 0);
    @(negedge clk); rstN = 1'b1;
    drive(1'b1, 1'b0, 3'd1, UB, 32'h0); #1;
    chk("R10 owner cleared", regRdata, 32'h0);
    idle();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule